// File: doc/BRIEF.md
# Voice Group Block Sequencer

This block plays one voice group out of a byte-wide voice store. A group is an ordered list of block numbers held in a shared block table. Each block is a fixed-length run of bytes, and several groups may list the same block. A 12-entry descriptor array gives each group its first table index and its entry count. A start request names a group by number (1 to 12). The sequencer then walks that group's table entries in ascending order. For each entry it fetches the block number, then reads the block's bytes one at a time. It hands out one sample on each sample-rate tick.

Two sample formats are supported, and the format input is latched when a start is accepted:

- In 8-bit mode each byte is one sample.
- In 4-bit mode each byte gives two 4-bit codes, low nibble first. Each code is output zero-extended.

Reconstructing audio from the 4-bit codes is left to a later stage. The voice store and the block table share one read port with a fixed two-cycle read latency. A halt input stops playback at once. A start for another group while one is playing abandons the current group.

The controller has six states:

- IDLE: nothing playing.
- TBL_REQ: issue a read of a table entry.
- TBL_WAIT: wait out the latency and capture the block number.
- DAT_REQ: issue a read of a voice byte.
- DAT_WAIT: wait out the latency and capture the byte.
- PLAY: wait for ticks and emit samples.

The transitions are:

- From any state, halt goes to IDLE.
- From any state, an accepted start goes to TBL_REQ.
- TBL_REQ goes to TBL_WAIT, then on to DAT_REQ.
- DAT_REQ goes to DAT_WAIT, then on to PLAY.
- From PLAY, when a byte is used up:
  - the next byte goes to DAT_REQ;
  - at the end of a block with more entries left, go to TBL_REQ;
  - at the end of the last block, go to IDLE.

Top module: `vgs_player`

## Requirements
- R1: After reset, busy, done and sample_valid are all low.
- R2: A start with group g in 1..12 (binary on start_grp) and a nonzero count plays the table entries of descriptor g-1. It starts at that descriptor's first index and plays count entries in ascending table order. Each entry's byte is a block number.
- R3: The voice byte address is block × BLK_BYTES + offset. Offsets 0 to BLK_BYTES-1 are played in increasing order.
- R4: With fmt_nib=0, each byte produces one sample equal to the whole byte.
- R5: With fmt_nib=1, each byte produces two samples: bits 3:0 first, then bits 7:4. Both appear on sample[3:0] with sample[7:4]=0.
- R6: A sample appears only as a one-cycle sample_valid pulse in the cycle after a tick edge. Ticks that fall while a fetch is in progress produce no sample.
- R7: done pulses for exactly one cycle, in the same cycle as the last sample of the last block. busy is low in that cycle.
- R8: A start naming group 0, a group above 12, or a group with count 0 is ignored, both when idle and while playing.
- R9: An accepted start while busy abandons the current group and plays the new group from its first entry. The abandoned group gives no done pulse.
- R10: halt ends playback at the next edge: busy goes low with no done pulse and no further samples. halt takes priority over a simultaneous start.
- R11: Each read is a one-cycle mem_rd with mem_tbl=1 for a table read (address = entry index) or mem_tbl=0 for a voice read. mem_rdata is taken exactly two cycles after the request.
- R12: The sample format is latched when a start is accepted. Changing fmt_nib during playback has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Stop playback immediately |
| tick | input | 1 | Sample-rate strobe, one cycle per sample |
| fmt_nib | input | 1 | 1 = 4-bit codes, 0 = 8-bit samples |
| start | input | 1 | Start request strobe |
| start_grp | input | 4 | Group number 1..12 |
| grp_first | input | NUM_GROUPS×10 | Packed first table index per group (group g at slice g-1) |
| grp_count | input | NUM_GROUPS×10 | Packed table entry count per group |
| mem_rd | output | 1 | Read request to the table/voice store |
| mem_tbl | output | 1 | 1 = table read, 0 = voice byte read |
| mem_addr | output | ADDR_W | Read address |
| mem_rdata | input | 8 | Read data, valid two cycles after mem_rd |
| busy | output | 1 | A group is being played |
| done | output | 1 | One-cycle pulse at the end of a group |
| sample_valid | output | 1 | One-cycle strobe for sample |
| sample | output | 8 | Current sample or zero-extended 4-bit code |

## Verification
The in-line assertions check, on every cycle, the cycle-level rules:

- done coincides with a sample and with busy low;
- halt empties the pipeline at the next edge;
- every sample follows a tick;
- 4-bit codes keep the upper nibble clear;
- every read address stays inside the table or the voice store.

Only the bench scenarios can show that the sample stream is right. That covers the block order from the table, the byte order within a block, the nibble order, and block reuse across groups. It also covers the rules that involve a missing event: ignored requests leaving the stream untouched, a restart discarding the remainder of the old group, and a format change in mid-play having no effect.

// File: rtl/vgs_pkg.sv
package vgs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TBL_REQ,
        S_TBL_WAIT,
        S_DAT_REQ,
        S_DAT_WAIT,
        S_PLAY
    } vgs_state_e;

endpackage

// File: rtl/vgs_desc_sel.sv
module vgs_desc_sel #(
    parameter int NUM_GROUPS = 12,
    parameter int GRP_W      = 4,
    parameter int IDX_W      = 10,
    parameter int CNT_W      = 10
) (
    input  logic [GRP_W-1:0]            grp,
    input  logic [NUM_GROUPS*IDX_W-1:0] first_flat,
    input  logic [NUM_GROUPS*CNT_W-1:0] count_flat,
    output logic [IDX_W-1:0]            first,
    output logic [CNT_W-1:0]            count,
    output logic                        valid
);

    logic [IDX_W-1:0] first_a [NUM_GROUPS];
    logic [CNT_W-1:0] count_a [NUM_GROUPS];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_unpack
        assign first_a[g] = first_flat[g*IDX_W +: IDX_W];
        assign count_a[g] = count_flat[g*CNT_W +: CNT_W];
    end

    // group numbers are 1-based; group 0 and values above NUM_GROUPS select nothing
    always_comb begin
        first = '0;
        count = '0;
        for (int i = 0; i < NUM_GROUPS; i++) begin
            if (grp == GRP_W'(i + 1)) begin
                first = first_a[i];
                count = count_a[i];
            end
        end
        valid = (count != '0);
    end

endmodule

// File: rtl/vgs_addr_gen.sv
module vgs_addr_gen #(
    parameter int BLK_BYTES = 512,
    parameter int BLKNUM_W  = 8,
    parameter int OFF_W     = 9,
    parameter int VADDR_W   = 16
) (
    input  logic [BLKNUM_W-1:0] blk,
    input  logic [OFF_W-1:0]    off,
    output logic [VADDR_W-1:0]  addr
);

    localparam bit POW2 = (BLK_BYTES == (1 << OFF_W));

    if (POW2) begin : g_shift
        assign addr = (VADDR_W'(blk) << OFF_W) | VADDR_W'(off);
    end else begin : g_mult
        assign addr = VADDR_W'(blk) * VADDR_W'(BLK_BYTES) + VADDR_W'(off);
    end

endmodule

// File: rtl/vgs_sample_fmt.sv
module vgs_sample_fmt (
    input  logic [7:0] byte_in,
    input  logic       nib_mode,
    input  logic       upper,
    output logic [7:0] smp
);

    always_comb begin
        if (!nib_mode)  smp = byte_in;
        else if (upper) smp = {4'h0, byte_in[7:4]};
        else            smp = {4'h0, byte_in[3:0]};
    end

endmodule

// File: rtl/vgs_player.sv
module vgs_player
    import vgs_pkg::*;
#(
    parameter int NUM_GROUPS = 12,
    parameter int NUM_BLOCKS = 126,
    parameter int BLK_BYTES  = 512,
    parameter int TBL_DEPTH  = 960,
    localparam int GRP_W     = $clog2(NUM_GROUPS + 1),
    localparam int TBL_IDX_W = $clog2(TBL_DEPTH),
    localparam int CNT_W     = $clog2(TBL_DEPTH + 1),
    localparam int OFF_W     = $clog2(BLK_BYTES),
    localparam int VADDR_W   = $clog2(NUM_BLOCKS * BLK_BYTES),
    localparam int ADDR_W    = (VADDR_W > TBL_IDX_W) ? VADDR_W : TBL_IDX_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            halt,
    input  logic                            tick,
    input  logic                            fmt_nib,
    input  logic                            start,
    input  logic [GRP_W-1:0]                start_grp,
    input  logic [NUM_GROUPS*TBL_IDX_W-1:0] grp_first,
    input  logic [NUM_GROUPS*CNT_W-1:0]     grp_count,
    output logic                            mem_rd,
    output logic                            mem_tbl,
    output logic [ADDR_W-1:0]               mem_addr,
    input  logic [7:0]                      mem_rdata,
    output logic                            busy,
    output logic                            done,
    output logic                            sample_valid,
    output logic [7:0]                      sample
);

    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(BLK_BYTES - 1);

    vgs_state_e state, state_nx;

    logic [TBL_IDX_W-1:0] entry_idx;
    logic [CNT_W-1:0]     left;
    logic [7:0]           blk;
    logic [OFF_W-1:0]     off;
    logic [7:0]           data_byte;
    logic                 half, lat, nib_mode;
    logic [7:0]           sample_q;
    logic                 vld_q, done_q;

    logic [TBL_IDX_W-1:0] d_first;
    logic [CNT_W-1:0]     d_count;
    logic                 d_valid, start_ok;
    logic [VADDR_W-1:0]   vaddr;
    logic [7:0]           fmt_smp;
    logic                 byte_end, blk_end, last_entry;

    vgs_desc_sel #(
        .NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W), .IDX_W(TBL_IDX_W), .CNT_W(CNT_W)
    ) u_desc (
        .grp(start_grp), .first_flat(grp_first), .count_flat(grp_count),
        .first(d_first), .count(d_count), .valid(d_valid)
    );

    vgs_addr_gen #(
        .BLK_BYTES(BLK_BYTES), .BLKNUM_W(8), .OFF_W(OFF_W), .VADDR_W(VADDR_W)
    ) u_addr (
        .blk(blk), .off(off), .addr(vaddr)
    );

    vgs_sample_fmt u_fmt (
        .byte_in(data_byte), .nib_mode(nib_mode), .upper(half), .smp(fmt_smp)
    );

    assign start_ok   = start && d_valid;
    assign byte_end   = tick && (!nib_mode || half);
    assign blk_end    = (off == OFF_LAST);
    assign last_entry = (left == CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state logic: halt first, then restart, then the walk
    always_comb begin
        state_nx = state;
        if (halt) begin
            state_nx = S_IDLE;
        end else if (start_ok) begin
            state_nx = S_TBL_REQ;
        end else begin
            unique case (state)
                S_IDLE:     state_nx = S_IDLE;
                S_TBL_REQ:  state_nx = S_TBL_WAIT;
                S_TBL_WAIT: if (lat) state_nx = S_DAT_REQ;
                S_DAT_REQ:  state_nx = S_DAT_WAIT;
                S_DAT_WAIT: if (lat) state_nx = S_PLAY;
                S_PLAY: begin
                    if (byte_end) begin
                        if (!blk_end)        state_nx = S_DAT_REQ;
                        else if (last_entry) state_nx = S_IDLE;
                        else                 state_nx = S_TBL_REQ;
                    end
                end
                default:    state_nx = S_IDLE;
            endcase
        end
    end

    // datapath: walk pointers, captured read data and registered results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_idx <= '0;
            left      <= '0;
            blk       <= '0;
            off       <= '0;
            data_byte <= '0;
            half      <= 1'b0;
            lat       <= 1'b0;
            nib_mode  <= 1'b0;
            sample_q  <= '0;
            vld_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            vld_q  <= 1'b0;
            done_q <= 1'b0;
            if (halt) begin
                lat <= 1'b0;
            end else if (start_ok) begin
                entry_idx <= d_first;
                left      <= d_count;
                nib_mode  <= fmt_nib;
                lat       <= 1'b0;
            end else begin
                unique case (state)
                    S_TBL_REQ, S_DAT_REQ: lat <= 1'b0;
                    S_TBL_WAIT: begin
                        lat <= ~lat;
                        if (lat) begin
                            blk <= mem_rdata;
                            off <= '0;
                        end
                    end
                    S_DAT_WAIT: begin
                        lat <= ~lat;
                        if (lat) begin
                            data_byte <= mem_rdata;
                            half      <= 1'b0;
                        end
                    end
                    S_PLAY: begin
                        if (tick) begin
                            vld_q    <= 1'b1;
                            sample_q <= fmt_smp;
                            if (!byte_end) begin
                                half <= 1'b1;
                            end else if (!blk_end) begin
                                off <= off + 1'b1;
                            end else if (last_entry) begin
                                done_q <= 1'b1;
                            end else begin
                                entry_idx <= entry_idx + 1'b1;
                                left      <= left - 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        busy         = (state != S_IDLE);
        mem_rd       = (state == S_TBL_REQ) || (state == S_DAT_REQ);
        mem_tbl      = (state == S_TBL_REQ);
        mem_addr     = mem_tbl ? ADDR_W'(entry_idx) : ADDR_W'(vaddr);
        done         = done_q;
        sample_valid = vld_q;
        sample       = sample_q;
    end

    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_done_with_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sample_valid);
    assert_halt_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!busy && !sample_valid && !done));
    assert_sample_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> $past(tick));
    assert_nibble_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && nib_mode) |-> (sample[7:4] == 4'h0));
    assert_voice_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_tbl) |-> (mem_addr < ADDR_W'(NUM_BLOCKS * BLK_BYTES)));
    assert_table_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_tbl) |-> (mem_addr < ADDR_W'(TBL_DEPTH)));

endmodule

// File: tb/vgs_player_test.sv
`timescale 1ns/1ps
module vgs_player_test;

    localparam int NG = 12;
    localparam int NB = 126;
    localparam int BB = 16;
    localparam int TD = 960;
    localparam int IW = 10;
    localparam int CW = 10;
    localparam int AW = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt = 1'b0, tick = 1'b0, fmt_nib = 1'b0, start = 1'b0;
    logic [3:0] start_grp = '0;
    logic [NG*IW-1:0] grp_first;
    logic [NG*CW-1:0] grp_count;
    logic mem_rd, mem_tbl, busy, done, sample_valid;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_rdata, sample;

    logic [7:0] tbl [TD];
    logic [IW-1:0] gfirst [NG];
    logic [CW-1:0] gcount [NG];
    logic [7:0] p1 = '0, p2 = '0;

    int n_chk = 0, n_fail = 0, done_cnt = 0;
    bit finished = 0;
    logic [7:0] expq [$];

    always #2 clk = ~clk;

    vgs_player #(.NUM_GROUPS(NG), .NUM_BLOCKS(NB), .BLK_BYTES(BB), .TBL_DEPTH(TD)) uut (
        .clk(clk), .rst_n(rst_n), .halt(halt), .tick(tick), .fmt_nib(fmt_nib),
        .start(start), .start_grp(start_grp), .grp_first(grp_first), .grp_count(grp_count),
        .mem_rd(mem_rd), .mem_tbl(mem_tbl), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .sample_valid(sample_valid), .sample(sample)
    );

    function automatic logic [7:0] vbyte(int a);
        return 8'((a * 37 + (a >> 3)) ^ 'h5A);
    endfunction

    always_comb begin
        for (int i = 0; i < NG; i++) begin
            grp_first[i*IW +: IW] = gfirst[i];
            grp_count[i*CW +: CW] = gcount[i];
        end
    end

    // memory model with two-cycle read latency (R11)
    always @(posedge clk) begin
        if (mem_rd) p1 <= mem_tbl ? tbl[int'(mem_addr)] : vbyte(int'(mem_addr));
        else        p1 <= 8'h00;
        p2 <= p1;
    end
    assign mem_rdata = p2;

    initial begin
        forever begin
            repeat (7) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // monitor: pops the scoreboard as samples come out
    always @(negedge clk) begin
        if (rst_n) begin
            if (sample_valid) begin
                if (expq.size() == 0) begin
                    chk(0, "R6 R8 R9 R10 unexpected sample", int'(sample), -1);
                end else begin
                    automatic logic [7:0] e = expq.pop_front();
                    chk(sample == e, "R2 R3 R4 R5 sample value", int'(sample), int'(e));
                end
            end
            if (done) begin
                done_cnt++;
                chk(expq.size() == 0, "R7 done with samples pending", expq.size(), 0);
                chk(!busy, "R7 busy low at done", int'(busy), 0);
            end
        end
    end

    task automatic push_group(input int g, input bit nib);
        for (int e = 0; e < int'(gcount[g-1]); e++) begin
            automatic int b = int'(tbl[int'(gfirst[g-1]) + e]);
            for (int o = 0; o < BB; o++) begin
                automatic logic [7:0] v = vbyte(b * BB + o);
                if (nib) begin
                    expq.push_back({4'h0, v[3:0]});
                    expq.push_back({4'h0, v[7:4]});
                end else begin
                    expq.push_back(v);
                end
            end
        end
    endtask

    task automatic pulse_start(input int g, input bit nib);
        @(negedge clk);
        start = 1'b1;
        start_grp = 4'(g);
        fmt_nib = nib;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    task automatic play(input int g, input bit nib);
        pulse_start(g, nib);
        expq.delete();
        push_group(g, nib);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int d0;
        foreach (tbl[i]) tbl[i] = 8'h00;
        for (int i = 0; i < NG; i++) begin gfirst[i] = '0; gcount[i] = '0; end
        tbl[0] = 8'd5; tbl[1] = 8'd2; tbl[2] = 8'd9;
        gfirst[0] = 10'd0; gcount[0] = 10'd3;
        tbl[3] = 8'd2; tbl[4] = 8'd7;
        gfirst[1] = 10'd3; gcount[1] = 10'd2;
        tbl[5] = 8'd125;
        gfirst[3] = 10'd5; gcount[3] = 10'd1;
        tbl[959] = 8'd64;
        gfirst[11] = 10'd959; gcount[11] = 10'd1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R1 busy after reset", int'(busy), 0);
        chk(!done, "R1 done after reset", int'(done), 0);
        chk(!sample_valid, "R1 sample_valid after reset", int'(sample_valid), 0);

        // R2 R3 R4: three blocks, 8-bit
        d0 = done_cnt;
        play(1, 0);
        wait_idle();
        repeat (4) @(negedge clk);
        chk(expq.size() == 0, "R2 R4 group 1 complete", expq.size(), 0);
        chk(done_cnt == d0 + 1, "R7 one done for group 1", done_cnt - d0, 1);

        // R5 R12: 4-bit, block reused from group 1, format flipped mid-play
        d0 = done_cnt;
        play(2, 1);
        repeat (30) @(negedge clk);
        fmt_nib = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        chk(expq.size() == 0, "R5 R12 group 2 complete", expq.size(), 0);
        chk(done_cnt == d0 + 1, "R7 one done for group 2", done_cnt - d0, 1);

        // R8: ignored requests while idle
        pulse_start(3, 0);
        pulse_start(13, 0);
        pulse_start(0, 0);
        repeat (40) @(negedge clk);
        chk(!busy, "R8 ignored start while idle", int'(busy), 0);

        // R8: empty group while busy leaves playback untouched
        d0 = done_cnt;
        play(1, 0);
        repeat (100) @(negedge clk);
        pulse_start(3, 1);
        wait_idle();
        repeat (4) @(negedge clk);
        chk(expq.size() == 0, "R8 stream intact after empty start", expq.size(), 0);
        chk(done_cnt == d0 + 1, "R8 single done", done_cnt - d0, 1);

        // R9: restart into group 4 (last block number)
        d0 = done_cnt;
        play(1, 1);
        repeat (60) @(negedge clk);
        play(4, 0);
        wait_idle();
        repeat (4) @(negedge clk);
        chk(expq.size() == 0, "R9 R3 restart stream", expq.size(), 0);
        chk(done_cnt == d0 + 1, "R9 only new group done", done_cnt - d0, 1);

        // R10: halt mid-play
        d0 = done_cnt;
        play(1, 0);
        repeat (50) @(negedge clk);
        halt = 1'b1;
        @(posedge clk);
        #1 halt = 1'b0;
        expq.delete();
        @(negedge clk);
        chk(!busy, "R10 busy low after halt", int'(busy), 0);
        repeat (100) @(negedge clk);
        chk(!busy && done_cnt == d0, "R10 no done after halt", done_cnt - d0, 0);

        // R10: halt beats simultaneous start
        @(negedge clk);
        halt = 1'b1; start = 1'b1; start_grp = 4'd1;
        @(posedge clk);
        #1 halt = 1'b0; start = 1'b0;
        repeat (20) @(negedge clk);
        chk(!busy, "R10 halt wins over start", int'(busy), 0);

        // R11 R2: group 12 at the top table index
        d0 = done_cnt;
        play(12, 0);
        wait_idle();
        repeat (4) @(negedge clk);
        chk(expq.size() == 0, "R11 R2 group 12 stream", expq.size(), 0);
        chk(done_cnt == d0 + 1, "R7 one done for group 12", done_cnt - d0, 1);

        finish_run();
    end

endmodule